// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write-strobe qualifier of a byte-wide parallel flash port. It parses multi-cycle write sequences into single-cycle requests for the embedded operation engine: byte program, whole-array erase, single-block erase, boot-block lockout set, and entry into or exit from the identification mode. Several sequences share the same unlock prefix and differ in length (3, 4 or 6 writes). The block therefore walks one shared prefix state machine and branches on the third and sixth writes.

The block also holds the device mode (array read, identification, busy) and a sticky lockout flag that protects a 16 KiB boot block. A parameter places the boot block at the top or the bottom of the address space. An operation request moves the mode to busy, and an external done pulse returns it to array read. While the mode is identification, a combinational read-back path reports the lockout flag at a reserved boot-block address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the mode is array read (mode_o = 2'b00), the lockout flag is 0 and every request output is 0.
- R2: The writes AAh at an address with bits [14:0] = 5555h, then 55h at bits [14:0] = 2AAAh, then A0h at 5555h, then any address and data, produce a one-cycle prog_req_o in the cycle after the fourth write. prog_addr_o and prog_data_o carry that write's address and data, and the mode becomes busy (2'b10).
- R3: The six-write sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h produces a one-cycle chip_erase_req_o and enters busy mode. chip_keep_boot_o equals the lockout flag in that cycle.
- R4: The same five-write prefix followed by 30h at any address produces a one-cycle blk_erase_req_o and enters busy mode. blk_sel_o encodes the block as 0 boot, 1 first parameter, 2 second parameter, 3 96 KiB main, 4 128 KiB main. With BOOT_TOP=0 the blocks rise from address 0 in that order. With BOOT_TOP=1 the layout is mirrored, so the boot block occupies the top 16 KiB.
- R5: AAh@5555h, 55h@2AAAh, 90h@5555h pulses id_enter_o and sets mode 2'b01. In that mode a write of F0h at any address pulses id_exit_o and returns the mode to 2'b00. Every other write in that mode is ignored.
- R6: id_lock_vld_o is 1 exactly when the mode is 2'b01 and rd_addr_i lies in the boot block with bit 1 = 1 and bit 0 = 0. id_lock_o then equals the lockout flag; otherwise both outputs are 0.
- R7: The five-write erase prefix followed by 40h@5555h pulses lock_set_req_o and sets locked_o. locked_o stays 1 until reset.
- R8: While locked_o is 1, a program or block erase whose target lies in the boot block produces no request, and the mode stays array read.
- R9: While the mode is busy, every write is ignored. An op_done_i pulse returns the mode to array read.
- R10: In array read mode, any write that does not match the next expected address/data pair drops the partial sequence. The decoder then needs a complete new sequence before any request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_vld_i | input | 1 | Qualified write strobe, one cycle per bus write |
| wr_addr_i | input | 18 | Write address |
| wr_data_i | input | 8 | Write data |
| op_done_i | input | 1 | Embedded operation finished |
| rd_addr_i | input | 18 | Read address for lockout read-back |
| prog_req_o | output | 1 | Program request pulse |
| prog_addr_o | output | 18 | Program target address |
| prog_data_o | output | 8 | Program data |
| chip_erase_req_o | output | 1 | Whole-array erase request pulse |
| chip_keep_boot_o | output | 1 | Array erase must skip the boot block |
| blk_erase_req_o | output | 1 | Block erase request pulse |
| blk_sel_o | output | 3 | Block selected for erase |
| lock_set_req_o | output | 1 | Lockout set pulse |
| id_enter_o | output | 1 | Identification mode entry pulse |
| id_exit_o | output | 1 | Identification mode exit pulse |
| mode_o | output | 2 | 00 array read, 01 identification, 10 busy |
| locked_o | output | 1 | Sticky boot-block lockout flag |
| id_lock_vld_o | output | 1 | Lockout read-back address hit |
| id_lock_o | output | 1 | Lockout read-back value |

## Verification
The bench builds the decoder with BOOT_TOP=1 and the default 18-bit address and 8-bit data widths. The mirrored layout places the boot block at the top. Its lockout read-back address and the parameter blocks therefore fall outside the 5555h/2AAAh unlock region, so the block-select decode can be tested independently of the prefix matching. Random sequences with corrupted writes run both before and after lockout. This exercises request dropping for the boot block, a whole-array erase that keeps the boot block, and aborts at each prefix position.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    BLK_BOOT   = 3'd0,
    BLK_PAR_A  = 3'd1,
    BLK_PAR_B  = 3'd2,
    BLK_MAIN_S = 3'd3,
    BLK_MAIN_L = 3'd4
  } blk_e;

  typedef enum logic [1:0] {
    MODE_READ = 2'b00,
    MODE_ID   = 2'b01,
    MODE_BUSY = 2'b10
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E1, SQ_E2, SQ_E3
  } seq_e;

  typedef struct packed {
    logic prog;
    logic chip;
    logic blk;
    logic lock;
    logic id_in;
  } hit_t;

  localparam int unsigned CMD_AW = 15;
  localparam logic [CMD_AW-1:0] ADR_LO = 15'h5555;
  localparam logic [CMD_AW-1:0] ADR_HI = 15'h2AAA;

  localparam logic [7:0] CMD_UNLK1   = 8'hAA;
  localparam logic [7:0] CMD_UNLK2   = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERSETUP = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_BLK     = 8'h30;
  localparam logic [7:0] CMD_LOCK    = 8'h40;
  localparam logic [7:0] CMD_ID_IN   = 8'h90;
  localparam logic [7:0] CMD_ID_OUT  = 8'hF0;
endpackage

// File: rtl/fcd_blk_map.sv
module fcd_blk_map
  import fcd_pkg::*;
#(
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic [4:0] unit_i,   // address in 8 KiB units
  output blk_e       blk_o
);
  logic [4:0] u;

  generate
    if (BOOT_TOP) begin : g_top
      assign u = ~unit_i;
    end else begin : g_bot
      assign u = unit_i;
    end
  endgenerate

  always_comb begin
    if (u < 5'd2)       blk_o = BLK_BOOT;
    else if (u == 5'd2) blk_o = BLK_PAR_A;
    else if (u == 5'd3) blk_o = BLK_PAR_B;
    else if (u < 5'd16) blk_o = BLK_MAIN_S;
    else                blk_o = BLK_MAIN_L;
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CMD_AW-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  output hit_t                hit_o
);
  seq_e st_q, st_d;
  logic a_lo, a_hi;

  assign a_lo = (addr_i == ADR_LO);
  assign a_hi = (addr_i == ADR_HI);

  always_comb begin
    st_d  = st_q;
    hit_o = '0;
    if (wr_en_i) begin
      st_d = SQ_IDLE;  // any mismatch aborts
      unique case (st_q)
        SQ_IDLE: if (a_lo && data_i == CMD_UNLK1) st_d = SQ_U1;
        SQ_U1:   if (a_hi && data_i == CMD_UNLK2) st_d = SQ_U2;
        SQ_U2: begin
          if (a_lo && data_i == CMD_PROG)         st_d = SQ_PROG;
          else if (a_lo && data_i == CMD_ERSETUP) st_d = SQ_E1;
          else if (a_lo && data_i == CMD_ID_IN)   hit_o.id_in = 1'b1;
        end
        SQ_PROG: hit_o.prog = 1'b1;
        SQ_E1:   if (a_lo && data_i == CMD_UNLK1) st_d = SQ_E2;
        SQ_E2:   if (a_hi && data_i == CMD_UNLK2) st_d = SQ_E3;
        SQ_E3: begin
          if (data_i == CMD_BLK)                 hit_o.blk  = 1'b1;
          else if (a_lo && data_i == CMD_CHIP)   hit_o.chip = 1'b1;
          else if (a_lo && data_i == CMD_LOCK)   hit_o.lock = 1'b1;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else         st_q <= st_d;
  end

  // R3
  e3_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == SQ_E3) |-> $past(st_q == SQ_E2));

  // R2
  prog_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == SQ_PROG) |-> $past(st_q == SQ_U2));
endmodule

// File: rtl/fcd_mode_ctl.sv
module fcd_mode_ctl
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              op_done_i,
  input  hit_t              hit_i,
  input  blk_e              tgt_blk_i,
  output logic              wr_en_o,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              chip_req_o,
  output logic              keep_boot_o,
  output logic              blk_req_o,
  output blk_e              blk_sel_o,
  output logic              lock_req_o,
  output logic              id_in_o,
  output logic              id_out_o,
  output mode_e             mode_o,
  output logic              locked_o
);
  mode_e mode_q;
  logic  locked_q, tgt_drop;

  assign wr_en_o  = wr_vld_i && (mode_q == MODE_READ);
  assign tgt_drop = locked_q && (tgt_blk_i == BLK_BOOT);
  assign mode_o   = mode_q;
  assign locked_o = locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_READ;
      locked_q    <= 1'b0;
      prog_req_o  <= 1'b0;
      prog_addr_o <= '0;
      prog_data_o <= '0;
      chip_req_o  <= 1'b0;
      keep_boot_o <= 1'b0;
      blk_req_o   <= 1'b0;
      blk_sel_o   <= BLK_BOOT;
      lock_req_o  <= 1'b0;
      id_in_o     <= 1'b0;
      id_out_o    <= 1'b0;
    end else begin
      prog_req_o  <= 1'b0;
      chip_req_o  <= 1'b0;
      keep_boot_o <= 1'b0;
      blk_req_o   <= 1'b0;
      blk_sel_o   <= BLK_BOOT;
      lock_req_o  <= 1'b0;
      id_in_o     <= 1'b0;
      id_out_o    <= 1'b0;
      unique case (mode_q)
        MODE_READ: begin
          if (hit_i.prog && !tgt_drop) begin
            prog_req_o  <= 1'b1;
            prog_addr_o <= wr_addr_i;
            prog_data_o <= wr_data_i;
            mode_q      <= MODE_BUSY;
          end
          if (hit_i.chip) begin
            chip_req_o  <= 1'b1;
            keep_boot_o <= locked_q;
            mode_q      <= MODE_BUSY;
          end
          if (hit_i.blk && !tgt_drop) begin
            blk_req_o <= 1'b1;
            blk_sel_o <= tgt_blk_i;
            mode_q    <= MODE_BUSY;
          end
          if (hit_i.lock) begin
            lock_req_o <= 1'b1;
            locked_q   <= 1'b1;
          end
          if (hit_i.id_in) begin
            id_in_o <= 1'b1;
            mode_q  <= MODE_ID;
          end
        end
        MODE_ID: if (wr_vld_i && wr_data_i == CMD_ID_OUT) begin
          id_out_o <= 1'b1;
          mode_q   <= MODE_READ;
        end
        MODE_BUSY: if (op_done_i) mode_q <= MODE_READ;
        default: mode_q <= MODE_READ;
      endcase
    end
  end

  // R9
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BUSY && !op_done_i) |=>
      !(prog_req_o || chip_req_o || blk_req_o || lock_req_o || id_in_o));

  // R7
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);

  // R8
  boot_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_req_o |-> !($past(locked_q) && blk_sel_o == BLK_BOOT));

  // R5
  id_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_out_o |-> (mode_q == MODE_READ && $past(mode_q == MODE_ID)));

  // R3
  chip_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_req_o |-> mode_q == MODE_BUSY);

  // R2
  prog_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> $past(wr_vld_i));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 8,
  parameter bit          BOOT_TOP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              op_done_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              chip_erase_req_o,
  output logic              chip_keep_boot_o,
  output logic              blk_erase_req_o,
  output logic [2:0]        blk_sel_o,
  output logic              lock_set_req_o,
  output logic              id_enter_o,
  output logic              id_exit_o,
  output logic [1:0]        mode_o,
  output logic              locked_o,
  output logic              id_lock_vld_o,
  output logic              id_lock_o
);
  localparam int unsigned UNIT_W = 5;  // 32 units of 1/32 array

  hit_t  hit;
  blk_e  wr_blk, rd_blk, sel;
  mode_e mode;
  logic  wr_en;
  logic  unused_rd;

  assign unused_rd = ^rd_addr_i[ADDR_W-UNIT_W-1:2];

  fcd_blk_map #(.BOOT_TOP(BOOT_TOP)) u_wr_map (
    .unit_i(wr_addr_i[ADDR_W-1 -: UNIT_W]),
    .blk_o (wr_blk)
  );

  fcd_blk_map #(.BOOT_TOP(BOOT_TOP)) u_rd_map (
    .unit_i(rd_addr_i[ADDR_W-1 -: UNIT_W]),
    .blk_o (rd_blk)
  );

  fcd_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en),
    .addr_i (wr_addr_i[CMD_AW-1:0]),
    .data_i (wr_data_i),
    .hit_o  (hit)
  );

  fcd_mode_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_vld_i   (wr_vld_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .op_done_i  (op_done_i),
    .hit_i      (hit),
    .tgt_blk_i  (wr_blk),
    .wr_en_o    (wr_en),
    .prog_req_o (prog_req_o),
    .prog_addr_o(prog_addr_o),
    .prog_data_o(prog_data_o),
    .chip_req_o (chip_erase_req_o),
    .keep_boot_o(chip_keep_boot_o),
    .blk_req_o  (blk_erase_req_o),
    .blk_sel_o  (sel),
    .lock_req_o (lock_set_req_o),
    .id_in_o    (id_enter_o),
    .id_out_o   (id_exit_o),
    .mode_o     (mode),
    .locked_o   (locked_o)
  );

  assign blk_sel_o     = sel;
  assign mode_o        = mode;
  assign id_lock_vld_o = (mode == MODE_ID) && (rd_blk == BLK_BOOT) &&
                         (rd_addr_i[1:0] == 2'b10);
  assign id_lock_o     = id_lock_vld_o && locked_o;

  // R6
  id_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_lock_o |-> (mode_o == 2'b01 && locked_o));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 18;
  localparam bit TB_TOP = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_vld = 1'b0, op_done = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_req, chip_req, keep_boot, blk_req, lock_req, id_in, id_out;
  logic locked, id_vld, id_lock;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_data;
  logic [2:0] blk_sel;
  logic [1:0] mode;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model
  int m_st = 0;
  logic [1:0] m_mode = 2'b00;
  logic m_lock = 1'b0;
  logic e_prog, e_chip, e_keep, e_blk, e_lock, e_in, e_out;
  logic [2:0] e_sel;
  logic [AW-1:0] e_paddr;
  logic [7:0] e_pdata;

  always #10 clk = ~clk;  // 50 MHz

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(8), .BOOT_TOP(TB_TOP)) u_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_vld_i(wr_vld), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .op_done_i(op_done), .rd_addr_i(rd_addr),
    .prog_req_o(prog_req), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .chip_erase_req_o(chip_req), .chip_keep_boot_o(keep_boot),
    .blk_erase_req_o(blk_req), .blk_sel_o(blk_sel), .lock_set_req_o(lock_req),
    .id_enter_o(id_in), .id_exit_o(id_out), .mode_o(mode), .locked_o(locked),
    .id_lock_vld_o(id_vld), .id_lock_o(id_lock)
  );

  function automatic logic [2:0] blk_of(input logic [AW-1:0] a);
    logic [4:0] u;
    u = TB_TOP ? ~a[AW-1 -: 5] : a[AW-1 -: 5];
    if (u < 2) return 3'd0;
    if (u == 2) return 3'd1;
    if (u == 3) return 3'd2;
    if (u < 16) return 3'd3;
    return 3'd4;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic [AW-1:0] a, input logic [7:0] d);
    bit lo, hi;
    int ns;
    {e_prog, e_chip, e_keep, e_blk, e_lock, e_in, e_out} = '0;
    e_sel = 3'd0;
    if (m_mode == 2'b10) return;
    if (m_mode == 2'b01) begin
      if (d == 8'hF0) begin m_mode = 2'b00; e_out = 1; end
      return;
    end
    lo = (a[14:0] == 15'h5555);
    hi = (a[14:0] == 15'h2AAA);
    ns = 0;
    case (m_st)
      0: if (lo && d == 8'hAA) ns = 1;
      1: if (hi && d == 8'h55) ns = 2;
      2: if (lo && d == 8'hA0) ns = 3;
         else if (lo && d == 8'h80) ns = 4;
         else if (lo && d == 8'h90) begin m_mode = 2'b01; e_in = 1; end
      3: if (!(blk_of(a) == 3'd0 && m_lock)) begin
           e_prog = 1; e_paddr = a; e_pdata = d; m_mode = 2'b10;
         end
      4: if (lo && d == 8'hAA) ns = 5;
      5: if (hi && d == 8'h55) ns = 6;
      6: if (d == 8'h30) begin
           if (!(blk_of(a) == 3'd0 && m_lock)) begin
             e_blk = 1; e_sel = blk_of(a); m_mode = 2'b10;
           end
         end else if (lo && d == 8'h10) begin
           e_chip = 1; e_keep = m_lock; m_mode = 2'b10;
         end else if (lo && d == 8'h40) begin
           e_lock = 1; m_lock = 1;
         end
      default: ;
    endcase
    m_st = ns;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_vld = 1; wr_addr = a; wr_data = d;
    model_step(a, d);
    @(negedge clk);
    wr_vld = 0;
    check(req, {18'd0, prog_req, chip_req, keep_boot, blk_req, blk_sel, lock_req,
                id_in, id_out, mode, locked},
               {18'd0, e_prog, e_chip, e_keep, e_blk, e_sel, e_lock,
                e_in, e_out, m_mode, m_lock});
    if (e_prog) check(req, {6'd0, prog_addr, prog_data}, {6'd0, e_paddr, e_pdata});
  endtask

  task automatic pre3(input logic [7:0] c, input string req);
    wr(18'h05555, 8'hAA, req);
    wr(18'h02AAA, 8'h55, req);
    wr(18'h05555, c, req);
  endtask

  task automatic pre5(input string req);
    pre3(8'h80, req);
    wr(18'h05555, 8'hAA, req);
    wr(18'h02AAA, 8'h55, req);
  endtask

  task automatic done();
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0;
    if (m_mode == 2'b10) m_mode = 2'b00;
    check("R9 done", {30'd0, mode}, {30'd0, m_mode});
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    logic ev;
    rd_addr = a;
    #1;
    ev = (m_mode == 2'b01) && (blk_of(a) == 3'd0) && (a[1:0] == 2'b10);
    check(req, {30'd0, id_vld, id_lock}, {30'd0, ev, ev & m_lock});
  endtask

  // random write, sometimes replaced by junk (R10)
  task automatic wr_r(input logic [AW-1:0] a, input logic [7:0] d);
    if ($urandom % 12 == 0) wr(AW'($urandom), 8'($urandom), "R10 junk");
    else wr(a, d, "R9 random");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {18'd0, prog_req, chip_req, blk_req, lock_req, id_in, id_out, mode, locked,
                       id_vld, id_lock, 3'd0},
                      32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {30'd0, mode}, 32'd0);

    // R2 program to main block
    pre3(8'hA0, "R2");
    wr(18'h01234, 8'h5A, "R2 program");
    check("R2 busy", {30'd0, mode}, 32'd2);
    // R9 ignored while busy
    pre3(8'hA0, "R9 busy ignore");
    wr(18'h00010, 8'h11, "R9 busy ignore");
    done();

    // R3 chip erase unlocked
    pre5("R3");
    wr(18'h05555, 8'h10, "R3 chip");
    done();

    // R4 each block
    pre5("R4"); wr(18'h3C100, 8'h30, "R4 boot");  done();
    pre5("R4"); wr(18'h3A000, 8'h30, "R4 par a"); done();
    pre5("R4"); wr(18'h38000, 8'h30, "R4 par b"); done();
    pre5("R4"); wr(18'h20000, 8'h30, "R4 main s"); done();
    pre5("R4"); wr(18'h00400, 8'h30, "R4 main l"); done();

    // R10 aborts at several positions
    wr(18'h05555, 8'hAA, "R10"); wr(18'h02AAB, 8'h55, "R10 bad addr");
    wr(18'h01000, 8'h77, "R10 no prog");
    pre3(8'h80, "R10"); wr(18'h05555, 8'hAB, "R10 bad data");
    wr(18'h02AAA, 8'h55, "R10"); wr(18'h05555, 8'h10, "R10 no chip");

    // R5/R6 ID mode unlocked
    pre3(8'h90, "R5 enter");
    rd_chk(18'h3C002, "R6 unlocked");
    rd_chk(18'h3C003, "R6 wrong low bits");
    rd_chk(18'h00002, "R6 non-boot");
    pre3(8'hA0, "R5 ignored in id");
    wr(18'h00000, 8'h42, "R5 ignored in id");
    wr(18'h12345, 8'hF0, "R5 exit");
    rd_chk(18'h3C002, "R6 after exit");

    // R7 lock
    pre5("R7"); wr(18'h05555, 8'h40, "R7 lock");
    check("R7 locked", {31'd0, locked}, 32'd1);
    // R8 boot guarded
    pre3(8'hA0, "R8"); wr(18'h3E000, 8'h00, "R8 prog boot dropped");
    pre5("R8"); wr(18'h3C000, 8'h30, "R8 blk boot dropped");
    pre3(8'hA0, "R8"); wr(18'h3A010, 8'h0F, "R8 prog par allowed"); done();
    pre5("R3"); wr(18'h05555, 8'h10, "R3 chip keep boot"); done();
    pre3(8'h90, "R6"); rd_chk(18'h3C002, "R6 locked"); wr(18'h0, 8'hF0, "R5 exit");

    // random mix
    for (int i = 0; i < 500; i++) begin
      int k;
      k = $urandom % 6;
      case (k)
        0: begin
          wr_r(18'h05555, 8'hAA); wr_r(18'h02AAA, 8'h55); wr_r(18'h05555, 8'hA0);
          wr_r(AW'($urandom), 8'($urandom));
        end
        1, 2: begin
          wr_r(18'h05555, 8'hAA); wr_r(18'h02AAA, 8'h55); wr_r(18'h05555, 8'h80);
          wr_r(18'h05555, 8'hAA); wr_r(18'h02AAA, 8'h55);
          if (k == 1) wr_r(18'h05555, 8'h10); else wr_r(AW'($urandom), 8'h30);
        end
        3: begin
          wr_r(18'h05555, 8'hAA); wr_r(18'h02AAA, 8'h55); wr_r(18'h05555, 8'h90);
          rd_chk({4'hF, 14'($urandom)} & 18'h3FFFE | 18'h2, "R6 random");
          wr_r(AW'($urandom), 8'hF0);
        end
        default: wr(AW'($urandom), 8'($urandom), "R10 noise");
      endcase
      if (m_mode == 2'b10) begin
        if ($urandom % 2) pre3(8'hA0, "R9 busy random");
        done();
      end
      if (m_mode == 2'b01) wr(18'h0, 8'hF0, "R5 random exit");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule